// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block lets an 8-bit controller core reach external code and data memory through a narrow pin budget. A single 8-bit port carries two things in turn. It first carries the low half of the address, which an external transparent latch captures. It then carries the data byte. A separate 8-bit port carries the upper address half for the whole access. Code fetches use their own active-low enable. Data reads and data writes each have their own active-low strobe.

A free-running phase counter divides the oscillator clock into bus cycles of six clocks. The latch-enable output pulses once per bus cycle, so it can also serve the board as a slow clock. The core raises a one-clock start strobe together with an address, a request kind and, for writes, a data byte. The access begins at the next bus-cycle boundary. The block answers with a one-clock done pulse, and for reads and fetches it also returns the byte it sampled. A code fetch to the low 4 KB is served on chip when the external-access input is high. In that case no bus activity occurs and the done pulse follows at once.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high, `bus_pse_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_ad_oe`, `bus_ale` and `rsp_done` are low.
- R2: After reset, `bus_ale` is high for exactly 2 clocks out of every 6, rising every 6 clocks, whether or not an access is in progress.
- R3: In clocks 0..2 of an external bus cycle the shared port is driven (`bus_ad_oe`=1) with address bits 7:0. `bus_ale` falls while that byte is on the port, so a latch that is transparent while `bus_ale` is high holds the low address during the strobe.
- R4: `bus_ahi` equals address bits 15:8 and stays constant while any strobe is low.
- R5: An external code fetch (`req_kind`=0) drives `bus_pse_n` low for exactly 3 clocks (clocks 3..5 of the bus cycle). `bus_rd_n` and `bus_wr_n` stay high.
- R6: A data read (`req_kind`=1, and 3 is treated the same) drives `bus_rd_n` low for 3 clocks with the port released (`bus_ad_oe`=0). The byte on `bus_ad_in` in the last strobe clock appears on `rsp_rdata` together with `rsp_done`. A fetch returns its byte the same way.
- R7: A data write (`req_kind`=2) drives `bus_wr_n` low for 3 clocks, with `bus_ad_oe`=1 and `bus_ad_out` holding the write byte steady.
- R8: A code fetch with `ea`=1 and address below 4096 produces no strobe. `rsp_done` rises on the clock after the start is taken. With `ea`=0, or an address of 4096 or more, every fetch runs on the bus.
- R9: A start strobe that arrives while an access is outstanding is ignored. It produces no strobe, no done pulse and no memory change.
- R10: Each accepted access yields exactly one `rsp_done` pulse, one clock long.
- R11: At most one of `bus_pse_n`, `bus_rd_n`, `bus_wr_n` is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ea | input | 1 | External-access select; high lets low code addresses stay on chip |
| req_start | input | 1 | One-clock access request |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 data read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Byte returned by the last read or fetch |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_ad_out | output | 8 | Shared port output value |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port input value |
| bus_ahi | output | 8 | Upper address port |
| bus_ale | output | 1 | Address latch enable |
| bus_pse_n | output | 1 | Code memory enable, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |

## Verification
The embedded assertions check several properties on every clock. They check that the strobes are mutually exclusive and that the latch-enable high time never exceeds two clocks. They check that the port is released under the read strobe, and that the write byte and upper address stay stable under a strobe. They also check that the done pulse is one clock long and that a strobe only falls after the latch enable has dropped. Other behaviours need the bench's scenarios against a modelled latch and memories. These are the exact strobe widths per request kind, the byte sampled at the end of a read, and the internal/external split set by `ea` and the 4 KB boundary. Two more also need those scenarios: that a start during a busy access leaves memory untouched, and the six-clock latch-enable period.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int INT_CODE_BYTES = 4096,
  parameter int CYC = 6,
  parameter int ALE_LEN = 2,
  parameter int ADDR_LEN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ea,
  input  logic          req_start,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic [AW-DW-1:0] bus_ahi,
  output logic          bus_ale,
  output logic          bus_pse_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n
);
  localparam int PW = $clog2(CYC);
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [AW:0] INT_LIM = (AW+1)'(INT_CODE_BYTES);

  logic [PW-1:0] ph;
  logic          busy, act, done_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  wire last      = (ph == PW'(CYC-1));
  wire int_hit   = ea && (req_kind == K_FETCH) && ({1'b0, req_addr} < INT_LIM);
  wire data_half = act && (ph >= PW'(ADDR_LEN));
  wire is_fetch  = (kind_q == K_FETCH);
  wire is_write  = (kind_q == K_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      busy   <= 1'b0;
      act    <= 1'b0;
      done_q <= 1'b0;
      kind_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      ph     <= last ? '0 : ph + 1'b1;
      done_q <= 1'b0;
      if (req_start && !busy) begin
        kind_q <= req_kind;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        if (int_hit) done_q <= 1'b1;
        else         busy   <= 1'b1;
      end
      if (busy && !act && last) act <= 1'b1;
      if (act && last) begin
        act    <= 1'b0;
        busy   <= 1'b0;
        done_q <= 1'b1;
        if (!is_write) rd_q <= bus_ad_in;
      end
    end
  end

  assign bus_ale    = !rst && (ph < PW'(ALE_LEN));
  assign bus_pse_n  = !(data_half && is_fetch);
  assign bus_rd_n   = !(data_half && !is_fetch && !is_write);
  assign bus_wr_n   = !(data_half && is_write);
  assign bus_ad_oe  = act && (!data_half || is_write);
  assign bus_ad_out = data_half ? wd_q : addr_q[DW-1:0];
  assign bus_ahi    = addr_q[AW-1:DW];
  assign rsp_rdata  = rd_q;
  assign rsp_done   = done_q;

  wire any_strobe = !bus_pse_n || !bus_rd_n || !bus_wr_n;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({!bus_pse_n, !bus_rd_n, !bus_wr_n}) <= 1);

  assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_ale && $past(bus_ale)) |=> !bus_ale);

  assert_strobe_after_latch_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(any_strobe) |-> !bus_ale);

  assert_read_release_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe);

  assert_write_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> (bus_ad_oe && $stable(bus_ad_out)));

  assert_ahi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && $past(any_strobe)) |-> $stable(bus_ahi));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ea = 1'b0, req_start = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic [7:0] rsp_rdata, bus_ad_out, bus_ad_in, bus_ahi;
  logic rsp_done, bus_ad_oe, bus_ale, bus_pse_n, bus_rd_n, bus_wr_n;

  always #2 clk = ~clk;

  xbus_seq u0 (.clk(clk), .rst(rst), .ea(ea), .req_start(req_start), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ahi(bus_ahi),
    .bus_ale(bus_ale), .bus_pse_n(bus_pse_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n));

  // external latch and memories
  logic [7:0] lat = 8'h0;
  logic [7:0] dmem [256];
  always_latch if (bus_ale) lat = bus_ad_out;
  assign bus_ad_in = !bus_pse_n ? (bus_ahi ^ lat ^ 8'h5A) : !bus_rd_n ? dmem[lat] : 8'hFF;
  initial for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
  always @(negedge clk) if (!bus_wr_n) dmem[lat] <= bus_ad_out;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitors
  int done_cnt, ps_cnt, rd_cnt, wr_cnt, bad_adr, bad_port;
  logic [15:0] cur_addr;
  logic [7:0] cur_wd;
  bit mon_on = 0;
  int gap = 0, hi_run = 0, ale_bad = 0, ale_rises = 0;
  logic prev_ale = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ale && !prev_ale) begin
        if (ale_rises > 0 && gap != 6) ale_bad++;
        ale_rises++;
        gap = 0;
      end
      gap++;
      if (bus_ale) hi_run++;
      else begin
        if (prev_ale && hi_run != 2) ale_bad++;
        hi_run = 0;
      end
      prev_ale = bus_ale;
    end
    if (mon_on) begin
      if (rsp_done) done_cnt++;
      if (!bus_pse_n) ps_cnt++;
      if (!bus_rd_n) rd_cnt++;
      if (!bus_wr_n) wr_cnt++;
      if (!bus_pse_n || !bus_rd_n || !bus_wr_n)
        if (lat != cur_addr[7:0] || bus_ahi != cur_addr[15:8]) bad_adr++;
      if (!bus_rd_n && bus_ad_oe) bad_port++;
      if (!bus_wr_n && (!bus_ad_oe || bus_ad_out != cur_wd)) bad_port++;
    end
  end

  task automatic clr_mon();
    done_cnt = 0; ps_cnt = 0; rd_cnt = 0; wr_cnt = 0; bad_adr = 0; bad_port = 0;
  endtask

  task automatic kick(input logic [1:0] k, input logic e, input logic [15:0] a, input logic [7:0] w);
    req_kind = k; ea = e; req_addr = a; req_wdata = w; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 30 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // kind, ea, addr, wdata, expected rdata, psen clocks, rd clocks, wr clocks, check rdata
  localparam logic [63:0] VEC [8] = '{
    64'h0_0_0100_00_5B_3_0_0_001,
    64'h0_1_0FFF_00_00_0_0_0_000,
    64'h0_1_1000_00_4A_3_0_0_001,
    64'h2_0_1234_A5_00_0_0_3_000,
    64'h1_0_1234_00_A5_0_3_0_001,
    64'h2_1_00FF_3C_00_0_0_3_000,
    64'h3_0_00FF_00_3C_0_3_0_001,
    64'h0_0_0FFF_00_AA_3_0_0_001
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_pse_n && bus_rd_n && bus_wr_n, "R1 strobes high in reset",
        {bus_pse_n, bus_rd_n, bus_wr_n}, 3'b111);
    chk(!bus_ad_oe && !bus_ale && !rsp_done, "R1 port/ale/done low in reset",
        {bus_ad_oe, bus_ale, rsp_done}, 0);
    rst = 1'b0;
    mon_on = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [63:0] e;
      e = VEC[v];
      cur_addr = e[55:40];
      cur_wd = e[39:32];
      clr_mon();
      kick(e[61:60], e[56], e[55:40], e[39:32]);
      wait_idle();
      chk(done_cnt == 1, $sformatf("R10 done count v%0d", v), done_cnt, 1);
      chk(ps_cnt == int'(e[23:20]), $sformatf("R5/R8 psen clocks v%0d", v), ps_cnt, e[23:20]);
      chk(rd_cnt == int'(e[19:16]), $sformatf("R6 rd clocks v%0d", v), rd_cnt, e[19:16]);
      chk(wr_cnt == int'(e[15:12]), $sformatf("R7 wr clocks v%0d", v), wr_cnt, e[15:12]);
      chk(bad_adr == 0, $sformatf("R3/R4 address on pins v%0d", v), bad_adr, 0);
      chk(bad_port == 0, $sformatf("R6/R7 port drive v%0d", v), bad_port, 0);
      if (e[0]) chk(rsp_rdata == e[31:24], $sformatf("R6 read data v%0d", v), rsp_rdata, e[31:24]);
    end

    // R8: internal fetch done follows the start by one clock
    clr_mon();
    req_kind = 2'd0; ea = 1'b1; req_addr = 16'h0ABC; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(rsp_done == 1'b1, "R8 internal done next clock", rsp_done, 1);
    repeat (8) @(negedge clk);
    chk(ps_cnt == 0 && rd_cnt == 0 && wr_cnt == 0, "R8 no strobe internal", ps_cnt + rd_cnt + wr_cnt, 0);

    // R9: start while busy is ignored
    clr_mon();
    cur_addr = 16'h1234;
    cur_wd = 8'h00;
    kick(2'd1, 1'b0, 16'h1234, 8'h00);
    @(negedge clk);
    kick(2'd2, 1'b0, 16'h0012, 8'h77);
    wait_idle();
    repeat (8) @(negedge clk);
    chk(done_cnt == 1, "R9 one done for two starts", done_cnt, 1);
    chk(wr_cnt == 0, "R9 no write strobe from ignored start", wr_cnt, 0);
    chk(rsp_rdata == 8'hA5, "R9 first request completed", rsp_rdata, 8'hA5);
    clr_mon();
    cur_addr = 16'h0012;
    kick(2'd1, 1'b0, 16'h0012, 8'h00);
    wait_idle();
    chk(rsp_rdata == 8'h00, "R9 ignored write left memory", rsp_rdata, 8'h00);

    chk(ale_bad == 0 && ale_rises > 20, "R2 ale period and width", ale_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule